// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer of 64 words of 36 bits. It joins a producer and a consumer that run on unrelated clocks. Words go in on the write clock when the write enable is high and the buffer has room. Words come out on the read clock when the read enable is high and the buffer holds data. Each side has two flags: a hard flag (full or empty) and a soft flag (almost-full or almost-empty). All four flags are active low, and each is computed only in the clock domain of the port that uses it.

The write and read positions are kept as binary counters. Each counter also has a Gray-coded copy, and only that copy crosses into the other domain, through two register stages. The soft-flag margin is one of four values picked by a two-bit select. The select is sampled when reset is released and held until the next reset. Reset is asynchronous and active low. Each port leaves reset through its own two-stage release chain, so the full flag rises on the second write-clock edge after release.

Top module: `dual_clock_fifo`

## Requirements
- R1: While rst_ni is low: full_n_o, empty_n_o and aempty_n_o are 0, afull_n_o is 1 and rdata_o is 0.
- R2: After rst_ni rises, full_n_o stays 0 after the first rising wclk_i edge and is 1 after the second.
- R3: The rising edge of rst_ni captures the margin from fsel_i as 4*(fsel_i+1), so 00=4, 01=8, 10=12 and 11=16. A change of fsel_i after that edge has no effect on the flags.
- R4: Words leave in the order they were written. After 64 writes with no reads, full_n_o is 0. After every word has been read, empty_n_o is 0.
- R5: A write request at a wclk_i edge while full_n_o is 0 is ignored: no stored word changes and the word is never read out.
- R6: A read request while empty_n_o is 0 is ignored, and rdata_o keeps its value.
- R7: A word written into an empty buffer raises empty_n_o after the second rising rclk_i edge that follows the write. Before that edge, empty_n_o stays 0. A read on the next edge puts the word on rdata_o.
- R8: afull_n_o is 0 exactly when the free space seen by the write side is no more than the margin.
- R9: aempty_n_o is 0 exactly when the word count seen by the read side is no more than the margin.
- R10: With both ports active at once on unrelated clocks, and the buffer repeatedly reaching full, every word arrives once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-port clock |
| rclk_i | input | 1 | Read-port clock |
| rst_ni | input | 1 | Asynchronous reset, active low; its rising edge captures the margin |
| fsel_i | input | 2 | Margin select for the soft flags |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | 36 | Write data |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | 36 | Read data register |
| full_n_o | output | 1 | Low when full (write clock) |
| afull_n_o | output | 1 | Low when free space is at or below the margin (write clock) |
| empty_n_o | output | 1 | Low when empty (read clock) |
| aempty_n_o | output | 1 | Low when the count is at or below the margin (read clock) |

## Verification
A write and a read can land in the same short window. When they do, the read side sees the new write position two edges late while its own position has just moved, and the write side sees the freed slot late while it keeps pushing against full. The bench runs a writer on a 10-time-unit clock and a reader on a 14-time-unit clock that reads only every other cycle. This keeps the buffer filling to full while reads drain it. The bench predicts acceptance from each port's own flag just before the edge and compares 200 words against their expected order.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int unsigned DATA_W   = 36;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned OFF_STEP = 4;

  // margin = OFF_STEP * (sel + 1)
  function automatic int unsigned sel_offset(input logic [SEL_W-1:0] sel);
    return (32'(sel) + 32'd1) * OFF_STEP;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] gray_o,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  function automatic logic [W-1:0] g2b(input logic [W-1:0] g);
    logic [W-1:0] b;
    b = g;
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  assign gray_o = s2_q;
  assign bin_o  = g2b(s2_q);
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcfifo_wr.sv
module dcfifo_wr #(
  parameter int unsigned AW = 6,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] off_i,
  input  logic [PW-1:0] rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_n_o,
  output logic          afull_n_o
);
  localparam int unsigned DEPTH = 2 ** AW;

  logic [1:0]    rst_q;
  logic          rst_n;
  logic [PW-1:0] bin_q, gray_q, bin_nxt;
  logic [PW-1:0] rg_s, rb_s, used, free;
  logic          full;

  // two-stage release; assertion is immediate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  dcfifo_sync #(.W(PW)) u_rsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_i (rgray_i),
    .gray_o (rg_s),
    .bin_o  (rb_s)
  );

  assign full      = (gray_q == {~rg_s[PW-1:PW-2], rg_s[PW-3:0]});
  assign full_n_o  = rst_n & ~full;
  assign we_o      = en_i & full_n_o;
  assign bin_nxt   = bin_q + PW'(1);
  assign used      = bin_q - rb_s;
  assign free      = PW'(DEPTH) - used;
  assign afull_n_o = ~rst_n | (free > off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (we_o) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign waddr_o = bin_q[AW-1:0];
  assign wgray_o = gray_q;

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && !full_n_o) |=> $stable(bin_q));
  assert_full_in_afull_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !full_n_o |-> !afull_n_o);
  assert_wgray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/dcfifo_rd.sv
module dcfifo_rd #(
  parameter int unsigned AW = 6,
  localparam int unsigned PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] off_i,
  input  logic [PW-1:0] wgray_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] rgray_o,
  output logic          empty_n_o,
  output logic          aempty_n_o
);
  logic [1:0]    rst_q;
  logic          rst_n;
  logic [PW-1:0] bin_q, gray_q, bin_nxt;
  logic [PW-1:0] wg_s, wb_s, count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n = rst_q[1];

  dcfifo_sync #(.W(PW)) u_wsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gray_i (wgray_i),
    .gray_o (wg_s),
    .bin_o  (wb_s)
  );

  assign empty_n_o  = rst_n & (gray_q != wg_s);
  assign re_o       = en_i & empty_n_o;
  assign bin_nxt    = bin_q + PW'(1);
  assign count      = wb_s - bin_q;
  assign aempty_n_o = rst_n & (count > off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (re_o) begin
      bin_q  <= bin_nxt;
      gray_q <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  assign raddr_o = bin_q[AW-1:0];
  assign rgray_o = gray_q;

  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_i && !empty_n_o) |=> $stable(bin_q));
  assert_empty_in_aempty_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !empty_n_o |-> !aempty_n_o);
  assert_rgray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int unsigned DW = dcfifo_pkg::DATA_W,
  parameter int unsigned AW = dcfifo_pkg::ADDR_W,
  localparam int unsigned PW = AW + 1,
  localparam int unsigned SW = dcfifo_pkg::SEL_W
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] fsel_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_n_o,
  output logic          afull_n_o,
  output logic          empty_n_o,
  output logic          aempty_n_o
);
  logic [PW-1:0] off_q;
  logic [PW-1:0] wgray, rgray;
  logic [AW-1:0] waddr, raddr;
  logic          we, re;

  // margin is quasi-static: captured on reset release only
  always_ff @(posedge rst_ni) begin
    off_q <= PW'(dcfifo_pkg::sel_offset(fsel_i));
  end

  dcfifo_wr #(.AW(AW)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (rst_ni),
    .en_i      (wr_en_i),
    .off_i     (off_q),
    .rgray_i   (rgray),
    .we_o      (we),
    .waddr_o   (waddr),
    .wgray_o   (wgray),
    .full_n_o  (full_n_o),
    .afull_n_o (afull_n_o)
  );

  dcfifo_rd #(.AW(AW)) u_rd (
    .clk_i      (rclk_i),
    .rst_ni     (rst_ni),
    .en_i       (rd_en_i),
    .off_i      (off_q),
    .wgray_i    (wgray),
    .re_o       (re),
    .raddr_o    (raddr),
    .rgray_o    (rgray),
    .empty_n_o  (empty_n_o),
    .aempty_n_o (aempty_n_o)
  );

  dcfifo_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  assert_rdata_hold_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_n_o) |=> $stable(rdata_o));
endmodule

// File: tb/dual_clock_fifo_tb_top.sv
module dual_clock_fifo_tb_top;
  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int N_STREAM    = 200;
  localparam logic [35:0] VEC [8] = '{
    36'h0_0000_0000, 36'hF_FFFF_FFFF, 36'hA_AAAA_AAAA, 36'h5_5555_5555,
    36'h8_0000_0001, 36'h1_2345_6789, 36'h0_0000_0001, 36'hF_0000_000F};

  logic        wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [1:0]  fsel = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic        full_n, afull_n, empty_n, aempty_n;
  int          n_chk = 0, n_fail = 0;

  dual_clock_fifo dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fsel_i(fsel),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .full_n_o(full_n), .afull_n_o(afull_n),
    .empty_n_o(empty_n), .aempty_n_o(aempty_n));

  // write edges odd times, read edges even times: never coincide
  always #(WCLK_PERIOD / 2) wclk = ~wclk;
  initial begin
    #1;
    forever #(RCLK_PERIOD / 2) rclk = ~rclk;
  end

  function automatic logic [35:0] val(input int i);
    return {4'(i), (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0000};
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic wr_word(input logic [35:0] d);
    @(negedge wclk); wr_en = 1'b1; wdata = d;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic rd_word();
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0; fsel = sel; wr_en = 1'b0; rd_en = 1'b0;
    repeat (5) @(posedge wclk);
    repeat (5) @(posedge rclk);
    #1;
    chk("R1 full_n", 36'(full_n), 36'd0);
    chk("R1 empty_n", 36'(empty_n), 36'd0);
    chk("R1 aempty_n", 36'(aempty_n), 36'd0);
    chk("R1 afull_n", 36'(afull_n), 36'd1);
    chk("R1 rdata", rdata, 36'd0);
    @(negedge wclk); #1; rst_n = 1'b1;
    @(posedge wclk); #1;
    chk("R2 full_n edge1", 36'(full_n), 36'd0);
    @(posedge wclk); #1;
    chk("R2 full_n edge2", 36'(full_n), 36'd1);
    repeat (3) @(negedge rclk);
  endtask

  task automatic fill_drain(input int off, input string tag);
    for (int k = 1; k <= 64; k++) begin
      wr_word(val(k - 1));
      if (k == 63 - off) chk({"R8 afull above ", tag}, 36'(afull_n), 36'd1);
      if (k == 64 - off) chk({"R8 afull at ", tag}, 36'(afull_n), 36'd0);
    end
    chk("R4 full after 64", 36'(full_n), 36'd0);
    wr_word(36'hD_EAD0_BEEF);
    chk("R5 still full", 36'(full_n), 36'd0);
    repeat (4) @(negedge rclk);
    chk("R9 aempty high when full", 36'(aempty_n), 36'd1);
    for (int k = 1; k <= 64; k++) begin
      rd_word();
      chk("R4 R5 order", rdata, val(k - 1));
      if (k == 63 - off) chk({"R9 aempty above ", tag}, 36'(aempty_n), 36'd1);
      if (k == 64 - off) chk({"R9 aempty at ", tag}, 36'(aempty_n), 36'd0);
    end
    chk("R4 empty after drain", 36'(empty_n), 36'd0);
    rd_word();
    chk("R6 rdata held on empty", rdata, val(63));
    repeat (4) @(negedge wclk);
    chk("R8 afull released", 36'(afull_n), 36'd1);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // margin 4, select changed after release (R3)
    do_reset(2'b00);
    fsel = 2'b11;

    // R7: two-edge visibility of a word written into empty buffer
    @(negedge wclk); wr_en = 1'b1; wdata = VEC[5];
    @(posedge wclk); wr_en <= 1'b0;
    @(posedge rclk); @(negedge rclk);
    chk("R7 empty after edge1", 36'(empty_n), 36'd0);
    @(posedge rclk); @(negedge rclk);
    chk("R7 not empty after edge2", 36'(empty_n), 36'd1);
    rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    chk("R7 data", rdata, VEC[5]);
    chk("R7 empty again", 36'(empty_n), 36'd0);
    rd_word();
    chk("R6 rdata held", rdata, VEC[5]);

    // table of vectors: write all, read back in order
    foreach (VEC[i]) wr_word(VEC[i]);
    repeat (4) @(negedge rclk);
    foreach (VEC[i]) begin
      rd_word();
      chk("R4 vector order", rdata, VEC[i]);
    end
    repeat (4) @(negedge wclk);
    fill_drain(4, "R3 margin4");

    do_reset(2'b10);
    fill_drain(12, "R3 margin12");

    // R10: concurrent stream, reader at half rate so full recurs
    do_reset(2'b01);
    begin
      bit saw_full = 1'b0;
      fork
        begin
          int i = 0;
          while (i < N_STREAM) begin
            @(negedge wclk);
            wr_en = 1'b1; wdata = val(i + 1000);
            if (full_n) i++;
            else saw_full = 1'b1;
          end
          @(negedge wclk); wr_en = 1'b0;
        end
        begin
          int j = 0;
          int cyc = 0;
          bit pend = 1'b0;
          while (j < N_STREAM) begin
            @(negedge rclk);
            if (pend) begin
              chk("R10 stream order", rdata, val(j + 1000));
              j++;
            end
            rd_en = (cyc % 2 == 0);
            pend = rd_en && empty_n;
            cyc++;
          end
          rd_en = 1'b0;
        end
      join
      chk("R10 R5 full reached", 36'(saw_full), 36'd1);
    end
    repeat (4) @(negedge rclk);
    chk("R10 empty at end", 36'(empty_n), 36'd0);

    summary();
    $finish;
  end
endmodule